// File: doc/BRIEF.md
# Handshaking Parallel I/O Port Block

This block provides two 8-bit data ports (A and B) and one 6-bit auxiliary port (C). A processor-side decoder hands it one read or write strobe per register. A command register supplies each data port's direction, each port's interrupt enable and a 2-bit mode for the auxiliary port. In plain mode a data port is a simple output latch or a transparent input. In handshake mode the auxiliary port lends three of its pins to a data port: a strobe input from the peripheral and two outputs, buffer-full and interrupt request.

The handshake sequence depends on the direction. On input, the peripheral strobe captures the port pins and marks the buffer full. Releasing the strobe requests an interrupt. A processor read then drops the request, and one clock later drops buffer-full. On output, a processor write loads the latch, marks the buffer full and drops the request. The peripheral strobe empties the buffer, and releasing it raises the request. Pin direction is given as separate output-enable signals.

Top module: `hs_pport`

## Requirements
- R1: After reset every output latch reads zero, both buffer-full and both request flags are low, and with zero command inputs every output enable is low.
- R2: In plain mode a write to port A or B loads its output latch on that clock edge. When the direction bit is 1 the output enable is high and the read value is the latch.
- R3: In plain mode with the direction bit 0, the port read value follows the live pins combinationally.
- R4: Auxiliary mode 2'b00 makes all six port C pins inputs (enables 6'h00) and the C read value the pins. Mode 2'b11 makes all six outputs (enables 6'h3F) driving the port C latch.
- R5: Mode 2'b01 puts port A in handshake on C bit 0 (request out), bit 1 (buffer-full out) and bit 2 (active-low strobe in). Bits 3 to 5 are outputs from the port C latch (enables 6'h3B).
- R6: Mode 2'b10 adds port B in handshake on C bit 3 (request out), bit 4 (buffer-full out) and bit 5 (strobe in) (enables 6'h1B).
- R7: In handshake input, a strobe falling to 0 latches the pins and sets buffer-full on the third rising clock edge after the fall. A strobe returning to 1 sets the request on the third edge after the rise.
- R8: In handshake input, a read clears the request at the read's clock edge and buffer-full one edge later.
- R9: In handshake output, a write sets buffer-full and clears the request at its edge. A strobe fall clears buffer-full, and the strobe rise then sets the request, each with the R7 latency.
- R10: A port's request pin on port C is high only while its request flag and its interrupt enable are both high. The flag output stays visible regardless of the enable.
- R11: In handshake input, if a strobe capture and a read fall on the same edge, buffer-full stays set and the new pin value is latched. The read returns the previously latched byte, and the request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_a_i | input | 1 | Write strobe, port A |
| wr_b_i | input | 1 | Write strobe, port B |
| wr_c_i | input | 1 | Write strobe, port C latch |
| rd_a_i | input | 1 | Read strobe, port A |
| rd_b_i | input | 1 | Read strobe, port B |
| wdata_i | input | 8 | Write data |
| dir_a_i | input | 1 | Port A direction, 1 = output |
| dir_b_i | input | 1 | Port B direction, 1 = output |
| ien_a_i | input | 1 | Port A interrupt enable |
| ien_b_i | input | 1 | Port B interrupt enable |
| cmode_i | input | 2 | Port C mode |
| pa_i | input | 8 | Port A pin input |
| pa_o | output | 8 | Port A pin output |
| pa_oe_o | output | 1 | Port A output enable |
| pb_i | input | 8 | Port B pin input |
| pb_o | output | 8 | Port B pin output |
| pb_oe_o | output | 1 | Port B output enable |
| pc_i | input | 6 | Port C pin input |
| pc_o | output | 6 | Port C pin output |
| pc_oe_o | output | 6 | Port C per-pin output enable |
| a_rdata_o | output | 8 | Port A read value |
| b_rdata_o | output | 8 | Port B read value |
| c_rdata_o | output | 6 | Port C read value |
| bf_a_o | output | 1 | Port A buffer-full flag |
| irq_a_o | output | 1 | Port A request flag |
| bf_b_o | output | 1 | Port B buffer-full flag |
| irq_b_o | output | 1 | Port B request flag |

## Verification
On a handshake input port, a synchronised strobe capture can reach the edge detector in the same cycle as a processor read. The read would clear buffer-full, while the capture must set it. The bench holds the strobe low and raises the read strobe in the cycle just before the third edge, so both events act on one edge. It then checks four things: the byte returned before that edge is the old one, buffer-full is still set both on that edge and one edge later, the latch holds the new pin value, and the request is cleared.

// File: rtl/hs_pport_pkg.sv
package hs_pport_pkg;
  typedef enum logic [1:0] {
    PCM_ALL_IN  = 2'b00,
    PCM_A_HS    = 2'b01,
    PCM_AB_HS   = 2'b10,
    PCM_ALL_OUT = 2'b11
  } pc_mode_e;
endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_ni,
  output logic fall_o,
  output logic rise_o
);
  localparam int MSB = STAGES - 1;
  logic [MSB:0] sync_q;
  logic         last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[MSB-1:0], stb_ni};
      last_q <= sync_q[MSB];
    end
  end

  assign fall_o = last_q & ~sync_q[MSB];
  assign rise_o = ~last_q & sync_q[MSB];
endmodule

// File: rtl/hs_chan.sv
module hs_chan #(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hs_en_i,
  input  logic         dir_out_i,
  input  logic         stb_ni,
  input  logic [W-1:0] pin_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ien_i,
  output logic [W-1:0] pin_o,
  output logic         oe_o,
  output logic [W-1:0] rdata_o,
  output logic         bf_o,
  output logic         irq_o,
  output logic         intr_o
);
  logic         fall, rise;
  logic [W-1:0] out_q, in_q;
  logic         bf_q, irq_q, rd_pend_q;
  logic         hs_in;

  hs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_ni(stb_ni),
    .fall_o(fall),
    .rise_o(rise)
  );

  assign hs_in = hs_en_i & ~dir_out_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (wr_i) out_q <= wdata_i;
      if (hs_in && fall) in_q <= pin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bf_q      <= 1'b0;
      irq_q     <= 1'b0;
      rd_pend_q <= 1'b0;
    end else if (!hs_en_i) begin
      bf_q      <= 1'b0;
      irq_q     <= 1'b0;
      rd_pend_q <= 1'b0;
    end else if (dir_out_i) begin
      rd_pend_q <= 1'b0;
      if (wr_i) begin
        bf_q  <= 1'b1;
        irq_q <= 1'b0;
      end else begin
        if (fall) bf_q <= 1'b0;
        if (rise) irq_q <= 1'b1;
      end
    end else begin
      // a capture on the read edge cancels the delayed empty
      rd_pend_q <= rd_i & ~fall;
      if (fall)           bf_q <= 1'b1;
      else if (rd_pend_q) bf_q <= 1'b0;
      if (rise)           irq_q <= 1'b1;
      else if (rd_i)      irq_q <= 1'b0;
    end
  end

  assign pin_o   = out_q;
  assign oe_o    = dir_out_i;
  assign rdata_o = dir_out_i ? out_q : (hs_en_i ? in_q : pin_i);
  assign bf_o    = bf_q;
  assign irq_o   = irq_q;
  assign intr_o  = irq_q & ien_i;
endmodule

// File: rtl/hs_pport.sv
module hs_pport
  import hs_pport_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_a_i,
  input  logic          wr_b_i,
  input  logic          wr_c_i,
  input  logic          rd_a_i,
  input  logic          rd_b_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          dir_a_i,
  input  logic          dir_b_i,
  input  logic          ien_a_i,
  input  logic          ien_b_i,
  input  logic [1:0]    cmode_i,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic          pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic          pb_oe_o,
  input  logic [CW-1:0] pc_i,
  output logic [CW-1:0] pc_o,
  output logic [CW-1:0] pc_oe_o,
  output logic [DW-1:0] a_rdata_o,
  output logic [DW-1:0] b_rdata_o,
  output logic [CW-1:0] c_rdata_o,
  output logic          bf_a_o,
  output logic          irq_a_o,
  output logic          bf_b_o,
  output logic          irq_b_o
);
  localparam int NP     = 2;
  localparam int HS_W   = 3;             // pins per handshake group
  localparam int INTR_O = 0;             // offsets inside a group
  localparam int BF_O   = 1;
  localparam int STB_O  = 2;

  pc_mode_e mode;
  assign mode = pc_mode_e'(cmode_i);

  logic [NP-1:0]  hs_en, dir, wr, rd, ien, stb_n, oe, bf, irq, intr;
  logic [DW-1:0]  pin_in [NP];
  logic [DW-1:0]  pin_out[NP];
  logic [DW-1:0]  rdata  [NP];
  logic [CW-1:0]  pc_q;

  assign hs_en[0] = (mode == PCM_A_HS) || (mode == PCM_AB_HS);
  assign hs_en[1] = (mode == PCM_AB_HS);
  assign dir      = {dir_b_i, dir_a_i};
  assign wr       = {wr_b_i, wr_a_i};
  assign rd       = {rd_b_i, rd_a_i};
  assign ien      = {ien_b_i, ien_a_i};
  assign pin_in[0] = pa_i;
  assign pin_in[1] = pb_i;

  for (genvar p = 0; p < NP; p++) begin : g_ch
    assign stb_n[p] = pc_i[p*HS_W + STB_O];
    hs_chan #(.W(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hs_en_i  (hs_en[p]),
      .dir_out_i(dir[p]),
      .stb_ni   (stb_n[p]),
      .pin_i    (pin_in[p]),
      .wr_i     (wr[p]),
      .rd_i     (rd[p]),
      .wdata_i  (wdata_i),
      .ien_i    (ien[p]),
      .pin_o    (pin_out[p]),
      .oe_o     (oe[p]),
      .rdata_o  (rdata[p]),
      .bf_o     (bf[p]),
      .irq_o    (irq[p]),
      .intr_o   (intr[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (wr_c_i) pc_q <= wdata_i[CW-1:0];
  end

  always_comb begin
    pc_o    = pc_q;
    pc_oe_o = '0;
    unique case (mode)
      PCM_ALL_IN:  pc_oe_o = '0;
      PCM_ALL_OUT: pc_oe_o = '1;
      default: begin
        pc_oe_o = '1;
        for (int p = 0; p < NP; p++) begin
          if (hs_en[p]) begin
            pc_o[p*HS_W + INTR_O]    = intr[p];
            pc_o[p*HS_W + BF_O]      = bf[p];
            pc_oe_o[p*HS_W + STB_O]  = 1'b0;
          end
        end
      end
    endcase
  end

  assign c_rdata_o = (pc_oe_o & pc_o) | (~pc_oe_o & pc_i);
  assign pa_o      = pin_out[0];
  assign pb_o      = pin_out[1];
  assign pa_oe_o   = oe[0];
  assign pb_oe_o   = oe[1];
  assign a_rdata_o = rdata[0];
  assign b_rdata_o = rdata[1];
  assign bf_a_o    = bf[0];
  assign irq_a_o   = irq[0];
  assign bf_b_o    = bf[1];
  assign irq_b_o   = irq[1];
endmodule

// File: rtl/hs_pport_chk.sv
module hs_pport_chk #(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_a_i,
  input logic          wr_b_i,
  input logic          rd_a_i,
  input logic [DW-1:0] wdata_i,
  input logic          dir_a_i,
  input logic          dir_b_i,
  input logic          ien_a_i,
  input logic [1:0]    cmode_i,
  input logic [DW-1:0] pa_o,
  input logic [CW-1:0] pc_i,
  input logic [CW-1:0] pc_o,
  input logic [CW-1:0] pc_oe_o,
  input logic          irq_a_o,
  input logic          bf_b_o,
  input logic          irq_b_o
);
  logic a_hs, b_hs;
  assign a_hs = (cmode_i == 2'b01) || (cmode_i == 2'b10);
  assign b_hs = (cmode_i == 2'b10);

  // R2
  wr_latch_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a_i |=> pa_o == $past(wdata_i));

  // R4
  all_in_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmode_i == 2'b00) |-> pc_oe_o == '0);

  // R8
  rd_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_i && a_hs && !dir_a_i && $past(pc_i[2], 2) && $past(pc_i[2], 3))
    |=> !irq_a_o);

  // R9
  wr_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_b_i && b_hs && dir_b_i) |=> (!b_hs || !dir_b_i || (bf_b_o && !irq_b_o)));

  // R10
  intr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_hs && pc_o[0]) |-> (ien_a_i && irq_a_o));
endmodule

bind hs_pport hs_pport_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_a_i (wr_a_i),
  .wr_b_i (wr_b_i),
  .rd_a_i (rd_a_i),
  .wdata_i(wdata_i),
  .dir_a_i(dir_a_i),
  .dir_b_i(dir_b_i),
  .ien_a_i(ien_a_i),
  .cmode_i(cmode_i),
  .pa_o   (pa_o),
  .pc_i   (pc_i),
  .pc_o   (pc_o),
  .pc_oe_o(pc_oe_o),
  .irq_a_o(irq_a_o),
  .bf_b_o (bf_b_o),
  .irq_b_o(irq_b_o)
);

// File: tb/hs_pport_tb_top.sv
`timescale 1ns/1ps
module hs_pport_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_a_i = 0, wr_b_i = 0, wr_c_i = 0, rd_a_i = 0, rd_b_i = 0;
  logic [7:0] wdata_i = '0;
  logic       dir_a_i = 0, dir_b_i = 0, ien_a_i = 0, ien_b_i = 0;
  logic [1:0] cmode_i = 2'b00;
  logic [7:0] pa_i = '0, pb_i = '0;
  logic [5:0] pc_i = 6'h3F;
  logic [7:0] pa_o, pb_o, a_rdata_o, b_rdata_o;
  logic       pa_oe_o, pb_oe_o, bf_a_o, irq_a_o, bf_b_o, irq_b_o;
  logic [5:0] pc_o, pc_oe_o, c_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  hs_pport dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    check("R1 pa_o", pa_o, 0);
    check("R1 pc_o", pc_o, 0);
    check("R1 oe", {pa_oe_o, pb_oe_o, pc_oe_o}, 0);
    check("R1 flags", {bf_a_o, irq_a_o, bf_b_o, irq_b_o}, 0);
  endtask

  task automatic t_plain();
    dir_a_i = 1; wdata_i = 8'h96; wr_a_i = 1;
    step(); wr_a_i = 0;
    check("R2 pa_o", pa_o, 8'h96);
    check("R2 pa_oe", pa_oe_o, 1);
    check("R2 a_rdata", a_rdata_o, 8'h96);
    dir_b_i = 0; pb_i = 8'h3D; #1;
    check("R3 b_rdata", b_rdata_o, 8'h3D);
    pb_i = 8'hC4; #1;
    check("R3 b_rdata live", b_rdata_o, 8'hC4);
    dir_a_i = 0;
  endtask

  task automatic t_pc_modes();
    wdata_i = 8'h2A; wr_c_i = 1; step(); wr_c_i = 0;
    cmode_i = 2'b11; #1;
    check("R4 all out oe", pc_oe_o, 6'h3F);
    check("R4 all out data", pc_o, 6'h2A);
    cmode_i = 2'b00; pc_i = 6'h15; #1;
    check("R4 all in oe", pc_oe_o, 6'h00);
    check("R4 all in read", c_rdata_o, 6'h15);
    pc_i = 6'h3F;
    cmode_i = 2'b01; #1;
    check("R5 oe", pc_oe_o, 6'h3B);
    check("R5 driven", pc_o & pc_oe_o, 6'h28);
    cmode_i = 2'b10; #1;
    check("R6 oe", pc_oe_o, 6'h1B);
    check("R6 driven", pc_o & pc_oe_o, 6'h00);
    step();
  endtask

  task automatic t_strobe_in();
    cmode_i = 2'b01; dir_a_i = 0; ien_a_i = 1; step();
    pa_i = 8'h5A; pc_i[2] = 0;
    step(2);
    check("R7 bf not yet", bf_a_o, 0);
    step();
    check("R7 bf set", bf_a_o, 1);
    check("R7 latched", a_rdata_o, 8'h5A);
    check("R5 bf pin", pc_o[1], 1);
    pa_i = 8'hFF; #1;
    check("R7 held", a_rdata_o, 8'h5A);
    pc_i[2] = 1;
    step(2);
    check("R7 irq not yet", irq_a_o, 0);
    step();
    check("R7 irq set", irq_a_o, 1);
    check("R10 intr pin", pc_o[0], 1);
    ien_a_i = 0; #1;
    check("R10 pin gated", pc_o[0], 0);
    check("R10 flag visible", irq_a_o, 1);
    ien_a_i = 1;
    rd_a_i = 1; step(); rd_a_i = 0;
    check("R8 irq cleared", irq_a_o, 0);
    check("R8 bf still", bf_a_o, 1);
    step();
    check("R8 bf cleared", bf_a_o, 0);
  endtask

  task automatic t_collision();
    pa_i = 8'h11; pc_i[2] = 0; step(3);
    pc_i[2] = 1; step(3);
    check("R11 setup irq", irq_a_o, 1);
    pa_i = 8'h22; pc_i[2] = 0;
    step(2);
    rd_a_i = 1; #1;
    check("R11 read old", a_rdata_o, 8'h11);
    step(); rd_a_i = 0;
    check("R11 bf kept", bf_a_o, 1);
    check("R11 irq cleared", irq_a_o, 0);
    check("R11 new data", a_rdata_o, 8'h22);
    step();
    check("R11 bf kept later", bf_a_o, 1);
    pc_i[2] = 1; step(3);
  endtask

  task automatic t_strobe_out();
    cmode_i = 2'b10; dir_b_i = 1; ien_b_i = 1; step();
    wdata_i = 8'h3C; wr_b_i = 1; step(); wr_b_i = 0;
    check("R9 pb_o", pb_o, 8'h3C);
    check("R9 bf set", bf_b_o, 1);
    check("R9 irq low", irq_b_o, 0);
    check("R6 bf pin", pc_o[4], 1);
    pc_i[5] = 0; step(3);
    check("R9 bf cleared", bf_b_o, 0);
    check("R9 irq still low", irq_b_o, 0);
    pc_i[5] = 1; step(3);
    check("R9 irq set", irq_b_o, 1);
    check("R6 intr pin", pc_o[3], 1);
    ien_b_i = 0; #1;
    check("R10 B gated", pc_o[3], 0);
    wr_b_i = 1; step(); wr_b_i = 0;
    check("R9 rewrite clears irq", irq_b_o, 0);
  endtask

  initial begin
    #1;
    check("R1 async reset", {bf_a_o, bf_b_o, pb_o}, 0);
    step(2);
    rst_ni = 1;
    step();
    t_reset();
    t_plain();
    t_pc_modes();
    t_strobe_in();
    t_collision();
    t_strobe_out();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule